// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by walking a two-level page table. The table lives in an external memory that is addressed by words. A request carries the virtual address, the privilege mode of the requester and the kind of access. The block reads one entry from the first-level table, whose location comes from a page-table base input. It then reads one entry from the second-level table that the first entry points to, and answers with either a translated address or a fault code.

The virtual page number is split into two equal index fields. Each index selects a 4-byte entry inside a table of 2^IDX_W entries. The page offset of OFF_W bits passes through unchanged.

The entry layout is as follows:

- bit 0 is valid.
- bit 1 grants read.
- bit 2 grants write.
- bit 3 grants execute.
- bit 4 marks the page kernel-only.
- bits PA_W-1:OFF_W hold the page number of the next table or of the target page.

Access codes are 00 read, 01 write, 10 execute and 11 reserved. Response status codes are 00 success, 01 page fault and 10 protection fault. The response level bit is 0 for the first level and 1 for the second level.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_rd_en` are 0.
- R2: A request is taken only while `req_ready` is 1. A `req_valid` raised during a walk is ignored: it neither changes the response nor starts a second walk.
- R3: In the cycle after a request is taken, the block issues one read at word address (page of `ptbr`) * 2^(OFF_W-2) + first index. The first index is the top IDX_W bits of the virtual address, and the low OFF_W bits of `ptbr` are ignored.
- R4: When the first-level entry is valid, the block issues one further read, one cycle later. Its word address is (entry bits PA_W-1:OFF_W) * 2^(OFF_W-2) + second index.
- R5: A first-level entry with bit 0 clear gives status 01 and level 0, with `rsp_paddr` 0. `rsp_valid` rises 3 cycles after acceptance, and no second read is issued.
- R6: A valid first-level entry followed by a second-level entry with bit 0 clear gives status 01 and level 1, with `rsp_paddr` 0.
- R7: For a valid second-level entry, a read needs bit 1, a write needs bit 2 and an execute needs bit 3. Access code 11 is never allowed. A denied access gives status 10 and level 1, with `rsp_paddr` 0.
- R8: With `req_user` 1, a second-level entry whose bit 4 is set gives status 10. With `req_user` 0, bit 4 has no effect.
- R9: Only bit 0 of the first-level entry is examined. Its permission and kernel bits do not affect the result.
- R10: A permitted access gives status 00, level 1 and `rsp_paddr` = {second-level entry bits PA_W-1:OFF_W, virtual offset}. `rsp_valid` rises 4 cycles after acceptance.
- R11: `rsp_valid` is a one-cycle pulse. `req_ready` stays 0 from acceptance through the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request can be taken |
| req_vaddr | input | 2*IDX_W+OFF_W | Virtual address |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| ptbr | input | PA_W | Page-table base; its page bits are sampled when the request is taken |
| mem_rd_en | output | 1 | Table memory read strobe |
| mem_rd_addr | output | PA_W-2 | Table memory word address |
| mem_rd_data | input | PA_W | Read data, valid one cycle after the strobe |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 00 success, 01 page fault, 10 protection fault |
| rsp_level | output | 1 | Table level of the last entry read (0 or 1) |
| rsp_paddr | output | PA_W | Physical address, 0 on a fault |

## Verification
The bench builds the walker with IDX_W=2, OFF_W=6 and PA_W=12, so each table holds four entries and the whole table memory is 1024 words. At this size it can try all 32 flag patterns of a second-level entry against every access code in both privilege modes. It can also walk all 16 virtual page numbers against a first-level table that mixes valid and invalid entries carrying stray permission bits. Expected addresses, status codes and latencies are worked out arithmetically from the entries the bench writes.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  // Entry flag positions
  localparam int unsigned PTE_V = 0;
  localparam int unsigned PTE_R = 1;
  localparam int unsigned PTE_W = 2;
  localparam int unsigned PTE_X = 3;
  localparam int unsigned PTE_K = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    ST_OK   = 2'b00,
    ST_PAGE = 2'b01,
    ST_PROT = 2'b10
  } walk_status_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_READ_L1,
    W_READ_L2,
    W_CHECK,
    W_RESPOND
  } walk_state_e;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic [PA_W-1:0]  table_base,
  input  logic [IDX_W-1:0] index,
  output logic [PA_W-3:0]  word_addr
);
  localparam int unsigned PAD_W = PA_W - IDX_W - 2;

  logic [PA_W-1:0] byte_addr;

  // Only the page bits of the base matter; tables are page-aligned.
  always_comb begin
    byte_addr = {table_base[PA_W-1:OFF_W], {OFF_W{1'b0}}}
              + {{PAD_W{1'b0}}, index, 2'b00};
    word_addr = byte_addr[PA_W-1:2];
  end
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import pt_walk_pkg::*;
#(
  parameter int unsigned PA_W = 32
) (
  input  logic [PA_W-1:0] entry,
  input  logic            user,
  input  logic [1:0]      acc,
  output logic [1:0]      status
);
  logic grant;

  always_comb begin
    unique case (acc)
      ACC_READ:  grant = entry[PTE_R];
      ACC_WRITE: grant = entry[PTE_W];
      ACC_EXEC:  grant = entry[PTE_X];
      default:   grant = 1'b0;
    endcase
    if (user && entry[PTE_K]) grant = 1'b0;

    if (!entry[PTE_V])  status = ST_PAGE;
    else if (!grant)    status = ST_PROT;
    else                status = ST_OK;
  end

  // R8
  always_comb begin
    if (entry[PTE_V] && user && entry[PTE_K])
      user_kernel_chk: assert (status == ST_PROT);
  end

  // R7
  always_comb begin
    if (entry[PTE_V] && acc == ACC_RSVD)
      rsvd_acc_chk: assert (status == ST_PROT);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [2*IDX_W+OFF_W-1:0] req_vaddr,
  input  logic                     req_user,
  input  logic [1:0]               req_acc,
  input  logic [PA_W-1:0]          ptbr,
  output logic                     mem_rd_en,
  output logic [PA_W-3:0]          mem_rd_addr,
  input  logic [PA_W-1:0]          mem_rd_data,
  output logic                     rsp_valid,
  output logic [1:0]               rsp_status,
  output logic                     rsp_level,
  output logic [PA_W-1:0]          rsp_paddr
);
  localparam int unsigned VA_W   = 2*IDX_W + OFF_W;
  localparam int unsigned LEVELS = 2;

  walk_state_e     state;
  logic [VA_W-1:0] vaddr_q;
  logic            user_q;
  logic [1:0]      acc_q;
  logic [PA_W-1:0] ptbr_q;

  logic [PA_W-1:0]  lvl_base [LEVELS];
  logic [IDX_W-1:0] lvl_idx  [LEVELS];
  logic [PA_W-3:0]  lvl_addr [LEVELS];
  logic [1:0]       leaf_status;

  assign lvl_base[0] = ptbr_q;
  assign lvl_base[1] = mem_rd_data;
  assign lvl_idx[0]  = vaddr_q[VA_W-1 -: IDX_W];
  assign lvl_idx[1]  = vaddr_q[OFF_W +: IDX_W];

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    ptw_entry_addr #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
      .table_base (lvl_base[lv]),
      .index      (lvl_idx[lv]),
      .word_addr  (lvl_addr[lv])
    );
  end

  ptw_entry_check #(.PA_W(PA_W)) u_check (
    .entry  (mem_rd_data),
    .user   (user_q),
    .acc    (acc_q),
    .status (leaf_status)
  );

  assign req_ready   = (state == W_IDLE);
  assign mem_rd_en   = (state == W_READ_L1) ||
                       (state == W_READ_L2 && mem_rd_data[PTE_V]);
  assign mem_rd_addr = (state == W_READ_L1) ? lvl_addr[0] : lvl_addr[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= W_IDLE;
      vaddr_q    <= '0;
      user_q     <= 1'b0;
      acc_q      <= 2'b00;
      ptbr_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_level  <= 1'b0;
      rsp_paddr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        W_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            user_q  <= req_user;
            acc_q   <= req_acc;
            ptbr_q  <= ptbr;
            state   <= W_READ_L1;
          end
        end
        W_READ_L1: state <= W_READ_L2;
        W_READ_L2: begin
          if (!mem_rd_data[PTE_V]) begin
            rsp_valid  <= 1'b1;
            rsp_status <= ST_PAGE;
            rsp_level  <= 1'b0;
            rsp_paddr  <= '0;
            state      <= W_RESPOND;
          end else begin
            state <= W_CHECK;
          end
        end
        W_CHECK: begin
          rsp_valid  <= 1'b1;
          rsp_status <= leaf_status;
          rsp_level  <= 1'b1;
          rsp_paddr  <= (leaf_status == ST_OK)
                        ? {mem_rd_data[PA_W-1:OFF_W], vaddr_q[OFF_W-1:0]}
                        : '0;
          state      <= W_RESPOND;
        end
        W_RESPOND: state <= W_IDLE;
        default:   state <= W_IDLE;
      endcase
    end
  end

  // R3
  accept_reads_l1_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> mem_rd_en);

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R11
  busy_at_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  // R10
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == ST_OK) |->
      rsp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]);

  // R5
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != ST_OK) |-> rsp_paddr == '0);

  // R5
  l1_fault_one_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_level == 1'b0) |-> !$past(mem_rd_en));
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int PA_W  = 12;
  localparam int OFF_W = 6;
  localparam int IDX_W = 2;
  localparam int VA_W  = 2*IDX_W + OFF_W;
  localparam int WPP   = 1 << (OFF_W-2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic req_user = 1'b0;
  logic [1:0] req_acc = 2'b00;
  logic [PA_W-1:0] ptbr = '0;
  logic mem_rd_en;
  logic [PA_W-3:0] mem_rd_addr;
  logic [PA_W-1:0] mem_rd_data = '0;
  logic rsp_valid;
  logic [1:0] rsp_status;
  logic rsp_level;
  logic [PA_W-1:0] rsp_paddr;

  logic [PA_W-1:0] mem [0:(1<<(PA_W-2))-1];

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
  end

  pt_walker #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_user(req_user), .req_acc(req_acc),
    .ptbr(ptbr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_level(rsp_level), .rsp_paddr(rsp_paddr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic walk(input logic [VA_W-1:0] va, input logic usr,
                      input logic [1:0] acc,
                      output int st, output int lv, output int pa,
                      output int cyc, output int nrd, output int a1,
                      output int a2, output int rdy_bad);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_user = usr; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1; nrd = 0; a1 = -1; a2 = -1; rdy_bad = 0;
    while (!rsp_valid && cyc < 12) begin
      if (mem_rd_en) begin
        if (nrd == 0) a1 = int'(mem_rd_addr);
        else a2 = int'(mem_rd_addr);
        nrd++;
      end
      if (req_ready) rdy_bad++;
      @(negedge clk);
      cyc++;
    end
    if (req_ready) rdy_bad++;
    if (rsp_valid) begin
      st = int'(rsp_status); lv = int'(rsp_level); pa = int'(rsp_paddr);
    end else begin
      st = -1; lv = -1; pa = -1;
    end
  endtask

  task automatic run_case(input logic [VA_W-1:0] va, input logic usr,
                          input logic [1:0] acc);
    int st, lv, pa, cyc, nrd, a1, a2, rb;
    int i1, i2, l1w, l2w, e_st, e_lv, e_pa, e_cyc, e_nrd;
    logic [PA_W-1:0] e1, e2;
    logic ok;
    string tag;
    i1  = int'(va[VA_W-1 -: IDX_W]);
    i2  = int'(va[OFF_W +: IDX_W]);
    l1w = int'(ptbr[PA_W-1:OFF_W]) * WPP + i1;
    e1  = mem[l1w];
    l2w = int'(e1[PA_W-1:OFF_W]) * WPP + i2;
    e2  = mem[l2w];
    if (!e1[0]) begin
      tag = "R5"; e_st = 1; e_lv = 0; e_pa = 0; e_cyc = 3; e_nrd = 1;
    end else if (!e2[0]) begin
      tag = "R6"; e_st = 1; e_lv = 1; e_pa = 0; e_cyc = 4; e_nrd = 2;
    end else begin
      ok = (acc == 2'd0 && e2[1]) || (acc == 2'd1 && e2[2]) ||
           (acc == 2'd2 && e2[3]);
      tag = "R7";
      if (usr && e2[4]) begin ok = 1'b0; tag = "R8"; end
      if (ok) tag = "R10";
      e_st = ok ? 0 : 2; e_lv = 1; e_cyc = 4; e_nrd = 2;
      e_pa = ok ? int'({e2[PA_W-1:OFF_W], va[OFF_W-1:0]}) : 0;
    end
    walk(va, usr, acc, st, lv, pa, cyc, nrd, a1, a2, rb);
    chk("R3 l1 addr", a1, l1w);
    if (e1[0]) chk("R4 l2 addr", a2, l2w);
    chk({tag, " status"}, st, e_st);
    chk({tag, " level"}, lv, e_lv);
    chk({tag, " paddr"}, pa, e_pa);
    chk({tag, " read count"}, nrd, e_nrd);
    chk("R11 latency", cyc, e_cyc);
    chk("R11 ready low while busy", rb, 0);
  endtask

  initial begin
    for (int i = 0; i < (1<<(PA_W-2)); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 mem_rd_en", int'(mem_rd_en), 0);

    // Sweep 1: every second-level flag pattern, every access, both modes.
    // R9: first-level entry has only its valid bit set.
    ptbr = '0;
    mem[1] = {6'd5, 6'b000001};
    for (int f = 0; f < 32; f++) begin
      mem[5*WPP + 2] = {6'((f + 7) % 64), 1'b0, 5'(f)};
      for (int u = 0; u < 2; u++)
        for (int a = 0; a < 4; a++)
          run_case({2'd1, 2'd2, 6'((f*3 + a) % 64)}, u[0], a[1:0]);
    end

    // Sweep 2: all page numbers, mixed first-level entries with stray bits.
    // R3: low bits of the base are ignored. R9: flags on L1 are ignored.
    ptbr = {6'd9, 6'h15};
    mem[9*WPP + 0] = {6'd20, 6'b011110};
    mem[9*WPP + 1] = {6'd21, 6'b000001};
    mem[9*WPP + 2] = {6'd22, 6'b111111};
    mem[9*WPP + 3] = {6'd23, 6'b010000};
    for (int p = 21; p <= 22; p++)
      for (int j = 0; j < 4; j++)
        mem[p*WPP + j] = (j == 1) ? {6'd33, 6'b001110}
                                  : {6'((j*9 + p) % 64), 6'b001111};
    for (int v = 0; v < 16; v++)
      for (int u = 0; u < 2; u++)
        run_case({4'(v), 6'(v*5 + 1)}, u[0], 2'd0);

    // R2: a request raised during a walk is ignored.
    begin
      int cyc, extra;
      ptbr = '0;
      mem[5*WPP + 2] = {6'd44, 6'b001111};
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = {2'd1, 2'd2, 6'd17};
      req_user = 1'b0; req_acc = 2'd0;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = {2'd0, 2'd0, 6'd3};
      cyc = 1;
      while (!rsp_valid && cyc < 12) begin @(negedge clk); cyc++; end
      req_valid = 1'b0;
      chk("R2 status of first request", int'(rsp_status), 0);
      chk("R2 paddr of first request", int'(rsp_paddr), (44 << 6) | 17);
      extra = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (rsp_valid || mem_rd_en) extra++;
      end
      chk("R2 no second walk", extra, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule